// File: doc/BRIEF.md
# I2C Receive-Only Slave with Address Rewrite Stall

This block is the receive side of an I2C slave, clocked by the system clock. Both bus lines enter as asynchronous levels and pass through synchronizers. The block detects Start, Repeated Start and Stop, shifts address and data bytes in from SDA, and compares each address byte against a compare register that the host can write. On the bus it acts only by pulling lines low: it pulls SDA low to acknowledge a byte, and it pulls SCL low to stretch the clock.

A simple host port on the system side offers four operations. The host can take the received byte, which clears the buffer-full flag. It can write the compare register, clear the overflow flag, and clear the interrupt flag. In 10-bit mode the compare register is used twice. It first holds the high-byte pattern. After that byte is acknowledged, the block stretches SCL until the host writes the low byte into the register. After the low byte is acknowledged, it stretches again until the host writes the high pattern back.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, neither bus line is pulled low and the buffer-full, overflow, interrupt and address-update flags are all 0.
- R2: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. After a Start, eight bits are sampled on SCL rising edges, MSB first. In 7-bit mode an address byte matches when its bits 7:1 equal compare-register bits 7:1 and its bit 0 (R/W) is 0. A matching byte is acknowledged by holding SDA low through the ninth SCL pulse.
- R3: Every acknowledged byte (address or data) is copied to the receive buffer and sets buffer-full when SCL falls after the eighth bit. The interrupt flag is set when SCL falls after the ninth pulse.
- R4: If buffer-full or overflow is already 1 when a matching byte completes, the byte is not acknowledged, the buffer keeps its old value, overflow becomes 1, and the interrupt flag is still set. An address byte refused this way ends the transfer.
- R5: A host read clears buffer-full. Only the overflow-clear operation clears overflow, and only the interrupt-clear operation clears the interrupt flag.
- R6: A non-matching address byte, or a read request (R/W = 1), is not acknowledged and raises no interrupt. The block then ignores the bus until the next Start. A Stop also returns the block to idle.
- R7: In 10-bit mode the first address byte must be 11110, A9, A8, 0 and must equal compare-register bits 7:1, with bit 0 equal to 0. The second byte must equal all 8 compare-register bits. After each acknowledged address byte, the address-update flag is set and SCL is held low. A host write to the compare register clears the flag and releases SCL. Data bytes never set the flag.
- R8: When the Start/Stop interrupt option is on, each Start and each Stop sets the interrupt flag. When the option is off, they do not.
- R9: A Repeated Start in the middle of a transfer restarts address matching from the first address byte.
- R10: SDA is pulled only during the acknowledge slot, and SCL is pulled only while the address-update flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| scl_in | input | 1 | SCL level as seen on the bus |
| sda_in | input | 1 | SDA level as seen on the bus |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| ss_irq_en | input | 1 | 1 makes Start and Stop raise the interrupt flag |
| host_rd | input | 1 | Pulse: host takes the received byte |
| host_wr_addr | input | 1 | Pulse: write host_wdata to the compare register |
| host_wdata | input | 8 | Compare-register write value |
| host_clr_ovf | input | 1 | Pulse: clear overflow |
| host_clr_irq | input | 1 | Pulse: clear interrupt flag |
| rx_data | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | A byte arrived while the buffer was busy |
| irq | output | 1 | Interrupt flag |
| addr_update | output | 1 | 10-bit compare register must be rewritten; SCL is held |

## Verification
The hardest situation to reach is the stalled 10-bit handshake. The bus is frozen with SCL held low, and the buffer is still full from the address byte. Only the right host sequence (read first, then rewrite the compare register) lets the second address byte be acknowledged. The bench models the bus as wired-AND, and its master waits while SCL is held. It stops between bytes to check that the stretch is active and that a host read alone does not release it. It then writes the compare register and checks that the stretch ends.

Overflow needs a full buffer when a matching byte arrives. The bench reaches it by skipping the host read, both in the data phase and on a fresh address.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ADDR    = 2'd1,
    PH_ADDR_LO = 2'd2,
    PH_DATA    = 2'd3
  } phase_e;

  // 7-bit address: upper seven bits equal, write direction only
  function automatic logic addr7_hit(input logic [BYTE_W-1:0] sh,
                                     input logic [BYTE_W-1:0] ref_a);
    return (sh[BYTE_W-1:1] == ref_a[BYTE_W-1:1]) && !sh[0];
  endfunction

  // 10-bit first byte: 11110 prefix, upper seven bits equal, write direction
  function automatic logic addr10_hi_hit(input logic [BYTE_W-1:0] sh,
                                         input logic [BYTE_W-1:0] ref_a);
    return (sh[BYTE_W-1:BYTE_W-5] == 5'b11110) &&
           (sh[BYTE_W-1:1] == ref_a[BYTE_W-1:1]) && !sh[0];
  endfunction

  // 10-bit second byte: full byte compare
  function automatic logic addr10_lo_hit(input logic [BYTE_W-1:0] sh,
                                         input logic [BYTE_W-1:0] ref_a);
    return sh == ref_a;
  endfunction

  function automatic phase_e phase_after_ack(input phase_e ph, input logic ten);
    case (ph)
      PH_ADDR:    return ten ? PH_ADDR_LO : PH_DATA;
      PH_ADDR_LO: return PH_DATA;
      default:    return PH_DATA;
    endcase
  endfunction

endpackage

// File: rtl/i2cs_sync_edge.sv
module i2cs_sync_edge #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
        prev  <= chain[STAGES-1];
      end
    end

    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~prev;
    assign fall[g] = ~chain[STAGES-1] & prev;
  end

endmodule

// File: rtl/i2cs_bit_engine.sv
module i2cs_bit_engine
  import i2cs_pkg::*;
#(
  parameter int W     = BYTE_W,
  localparam int CNT_W = $clog2(W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  output logic [W-1:0]     shreg,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             byte_done,
  output logic             ack_end
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(W + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (start || !run) begin
      bit_cnt <= '0;
    end else if (scl_rise && bit_cnt < ACK_SLOT) begin
      if (bit_cnt < LAST_BIT) shreg <= {shreg[W-2:0], sda_lvl};
      bit_cnt <= bit_cnt + 1'b1;
    end else if (scl_fall && bit_cnt == ACK_SLOT) begin
      bit_cnt <= '0;
    end
  end

  // falling edge that closes the eighth and the ninth pulse
  assign byte_done = run && !start && scl_fall && (bit_cnt == LAST_BIT);
  assign ack_end   = run && !start && scl_fall && (bit_cnt == ACK_SLOT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= ACK_SLOT); // R2
  AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_rise |=> $stable(shreg)); // R2

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         stop,
  input  logic         byte_done,
  input  logic         ack_end,
  input  logic [W-1:0] shreg,
  input  logic         ten_bit_mode,
  input  logic         ss_irq_en,
  input  logic         host_rd,
  input  logic         host_wr_addr,
  input  logic [W-1:0] host_wdata,
  input  logic         host_clr_ovf,
  input  logic         host_clr_irq,
  output phase_e       phase,
  output logic [W-1:0] rx_buf,
  output logic         buf_full,
  output logic         overflow,
  output logic         irq,
  output logic         upd_flag,
  output logic         sda_pull
);

  logic [W-1:0] addr_reg;
  logic         irq_pend;
  logic         upd_pend;
  phase_e       nxt_ph;
  logic         hit;
  logic         busy;
  logic         accept;

  always_comb begin
    case (phase)
      PH_ADDR:    hit = ten_bit_mode ? addr10_hi_hit(shreg, addr_reg)
                                     : addr7_hit(shreg, addr_reg);
      PH_ADDR_LO: hit = addr10_lo_hit(shreg, addr_reg);
      PH_DATA:    hit = 1'b1;
      default:    hit = 1'b0;
    endcase
  end

  assign busy   = buf_full | overflow;
  assign accept = hit & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      nxt_ph   <= PH_IDLE;
      addr_reg <= '0;
      rx_buf   <= '0;
      buf_full <= 1'b0;
      overflow <= 1'b0;
      irq      <= 1'b0;
      irq_pend <= 1'b0;
      upd_pend <= 1'b0;
      upd_flag <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      if (host_wr_addr) begin
        addr_reg <= host_wdata;
        upd_flag <= 1'b0;
      end
      if (host_rd)      buf_full <= 1'b0;
      if (host_clr_ovf) overflow <= 1'b0;
      if (host_clr_irq) irq      <= 1'b0;

      if (start || stop) begin
        phase    <= start ? PH_ADDR : PH_IDLE;
        sda_pull <= 1'b0;
        irq_pend <= 1'b0;
        upd_pend <= 1'b0;
        if (ss_irq_en) irq <= 1'b1;
      end else if (byte_done) begin
        if (!hit) begin
          phase <= PH_IDLE;
        end else if (busy) begin
          overflow <= 1'b1;
          irq_pend <= 1'b1;
          upd_pend <= 1'b0;
          nxt_ph   <= (phase == PH_DATA) ? PH_DATA : PH_IDLE;
        end else begin
          rx_buf   <= shreg;
          buf_full <= 1'b1;
          sda_pull <= 1'b1;
          irq_pend <= 1'b1;
          upd_pend <= ten_bit_mode && (phase != PH_DATA);
          nxt_ph   <= phase_after_ack(phase, ten_bit_mode);
        end
      end else if (ack_end) begin
        sda_pull <= 1'b0;
        if (irq_pend) irq      <= 1'b1;
        if (upd_pend) upd_flag <= 1'b1;
        irq_pend <= 1'b0;
        upd_pend <= 1'b0;
        phase    <= nxt_ph;
      end
    end
  end

  AST_NACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && busy |=> !sda_pull); // R4
  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && accept |=> buf_full && sda_pull && rx_buf == $past(shreg)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !host_clr_ovf |=> overflow); // R5
  AST_UPD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_flag) |-> $past(host_wr_addr)); // R7
  AST_IRQ_AT_ACK_END: assert property (@(posedge clk) disable iff (!rst_n)
    ack_end && irq_pend |=> irq); // R3

endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              ten_bit_mode,
  input  logic              ss_irq_en,
  input  logic              host_rd,
  input  logic              host_wr_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_clr_ovf,
  input  logic              host_clr_irq,
  output logic [BYTE_W-1:0] rx_data,
  output logic              buf_full,
  output logic              overflow,
  output logic              irq,
  output logic              addr_update
);

  localparam int CNT_W = $clog2(BYTE_W + 2);

  logic [1:0]        s_lvl, s_rise, s_fall;
  logic              scl_lvl, sda_lvl;
  logic              ev_start, ev_stop;
  logic              ev_byte_done, ev_ack_end;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  phase_e            phase;
  logic              upd_flag;

  i2cs_sync_edge #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({sda_in, scl_in}),
    .lvl  (s_lvl),
    .rise (s_rise),
    .fall (s_fall)
  );

  assign scl_lvl  = s_lvl[0];
  assign sda_lvl  = s_lvl[1];
  assign ev_start = s_fall[1] & scl_lvl & ~s_fall[0];
  assign ev_stop  = s_rise[1] & scl_lvl & ~s_fall[0];

  i2cs_bit_engine #(.W(BYTE_W)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (phase != PH_IDLE),
    .start    (ev_start),
    .scl_rise (s_rise[0]),
    .scl_fall (s_fall[0]),
    .sda_lvl  (sda_lvl),
    .shreg    (shreg),
    .bit_cnt  (bit_cnt),
    .byte_done(ev_byte_done),
    .ack_end  (ev_ack_end)
  );

  i2cs_ctrl #(.W(BYTE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (ev_start),
    .stop        (ev_stop),
    .byte_done   (ev_byte_done),
    .ack_end     (ev_ack_end),
    .shreg       (shreg),
    .ten_bit_mode(ten_bit_mode),
    .ss_irq_en   (ss_irq_en),
    .host_rd     (host_rd),
    .host_wr_addr(host_wr_addr),
    .host_wdata  (host_wdata),
    .host_clr_ovf(host_clr_ovf),
    .host_clr_irq(host_clr_irq),
    .phase       (phase),
    .rx_buf      (rx_data),
    .buf_full    (buf_full),
    .overflow    (overflow),
    .irq         (irq),
    .upd_flag    (upd_flag),
    .sda_pull    (sda_pull)
  );

  assign scl_pull    = upd_flag;
  assign addr_update = upd_flag;

  AST_SDA_PULL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> bit_cnt >= CNT_W'(BYTE_W)); // R10
  AST_SCL_PULL_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> !scl_lvl); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IDLE && !ev_start |=> !sda_pull); // R6

endmodule

// File: tb/i2c_addr_slave_tb.sv
module i2c_addr_slave_tb;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_pull, sda_pull;
  logic       ten_bit_mode = 1'b0, ss_irq_en = 1'b0;
  logic       host_rd = 1'b0, host_wr_addr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic       host_clr_ovf = 1'b0, host_clr_irq = 1'b0;
  logic [7:0] rx_data;
  logic       buf_full, overflow, irq, addr_update;
  logic       scl_bus, sda_bus;

  int n_checks = 0;
  int n_err    = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  assign scl_bus = scl_m & ~scl_pull;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_addr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .ten_bit_mode(ten_bit_mode), .ss_irq_en(ss_irq_en),
    .host_rd(host_rd), .host_wr_addr(host_wr_addr), .host_wdata(host_wdata),
    .host_clr_ovf(host_clr_ovf), .host_clr_irq(host_clr_irq),
    .rx_data(rx_data), .buf_full(buf_full), .overflow(overflow),
    .irq(irq), .addr_update(addr_update)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every new buffer load must match the oldest expected byte
  logic bf_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n && buf_full && !bf_q) begin
      if (exp_q.size() == 0) check("R3 unexpected buffer load", {24'd0, rx_data}, 32'hFFFF);
      else check("R3 buffer byte", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
    end
    bf_q = buf_full;
  end

  task automatic bus_start();
    sda_m = 1'b0; wait_q(Q); scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_q(Q); scl_m = 1'b1;
    while (!scl_bus) @(negedge clk);
    wait_q(Q); sda_m = 1'b0; wait_q(Q); scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q); scl_m = 1'b1; wait_q(Q); sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic clock_pulse();
    scl_m = 1'b1;
    while (!scl_bus) @(negedge clk);
    wait_q(Q); scl_m = 1'b0; wait_q(Q);
  endtask

  // driver: pushes the expected buffer content when an ACK is expected
  task automatic xfer(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ackbit;
    if (exp_ack) exp_q.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(Q / 2);
      clock_pulse();
    end
    sda_m = 1'b1; wait_q(Q / 2);
    scl_m = 1'b1;
    while (!scl_bus) @(negedge clk);
    wait_q(Q / 2); ackbit = sda_bus; wait_q(Q / 2);
    scl_m = 1'b0; wait_q(Q);
    check(tag, {31'd0, ~ackbit}, {31'd0, exp_ack});
  endtask

  task automatic pulse_rd();
    @(negedge clk); host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
  endtask
  task automatic pulse_clr_irq();
    @(negedge clk); host_clr_irq = 1'b1; @(negedge clk); host_clr_irq = 1'b0;
  endtask
  task automatic pulse_clr_ovf();
    @(negedge clk); host_clr_ovf = 1'b1; @(negedge clk); host_clr_ovf = 1'b0;
  endtask
  task automatic write_addr(input logic [7:0] a);
    @(negedge clk); host_wdata = a; host_wr_addr = 1'b1; @(negedge clk); host_wr_addr = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    wait_q(5); rst_n = 1'b1; wait_q(3);
    // R1 reset state
    check("R1 scl_pull", {31'd0, scl_pull}, 0);
    check("R1 sda_pull", {31'd0, sda_pull}, 0);
    check("R1 flags", {28'd0, buf_full, overflow, irq, addr_update}, 0);

    // R2 R3 R5: 7-bit write, address 0x5A
    write_addr(8'hB4);
    bus_start();
    xfer(8'hB4, 1'b1, "R2 7-bit address ACK");
    check("R3 irq after address", {31'd0, irq}, 1);
    check("R3 buffer full after address", {31'd0, buf_full}, 1);
    check("R10 sda released after slot", {31'd0, sda_pull}, 0);
    pulse_rd();
    check("R5 read clears buffer-full", {31'd0, buf_full}, 0);
    pulse_clr_irq();
    check("R5 irq clear", {31'd0, irq}, 0);
    xfer(8'h3C, 1'b1, "R3 data ACK");
    pulse_rd();
    xfer(8'hC3, 1'b1, "R3 data ACK second");
    // R4: buffer still full
    pulse_clr_irq();
    xfer(8'h11, 1'b0, "R4 NACK on full buffer");
    check("R4 overflow set", {31'd0, overflow}, 1);
    check("R4 irq still raised", {31'd0, irq}, 1);
    check("R4 buffer kept", {24'd0, rx_data}, 32'hC3);
    pulse_rd();
    xfer(8'h22, 1'b0, "R4 NACK while overflow pending");
    check("R5 overflow survives read", {31'd0, overflow}, 1);
    pulse_clr_ovf();
    check("R5 overflow cleared", {31'd0, overflow}, 0);
    xfer(8'h33, 1'b1, "R4 ACK after clear");
    pulse_rd();
    bus_stop();
    pulse_clr_irq();

    // R6: non-matching address and read request
    bus_start();
    xfer(8'h80, 1'b0, "R6 non-matching address NACK");
    xfer(8'hB4, 1'b0, "R6 ignored until next Start");
    check("R6 no irq", {31'd0, irq}, 0);
    bus_stop();
    bus_start();
    xfer(8'hB5, 1'b0, "R6 read request NACK");
    check("R6 no load on read request", {31'd0, buf_full}, 0);
    bus_stop();

    // R9: repeated start restarts address phase
    bus_start();
    xfer(8'hB4, 1'b1, "R9 first address ACK");
    pulse_rd();
    xfer(8'h10, 1'b1, "R9 data ACK");
    pulse_rd();
    bus_rstart();
    xfer(8'h10, 1'b0, "R9 byte after Sr treated as address");
    bus_rstart();
    xfer(8'hB4, 1'b1, "R9 address after Sr ACK");
    pulse_rd();
    xfer(8'h20, 1'b1, "R9 data after Sr ACK");
    bus_stop();
    pulse_clr_irq();

    // R4: address arrives while buffer still full
    bus_start();
    xfer(8'hB4, 1'b0, "R4 address NACK on full buffer");
    check("R4 overflow on address", {31'd0, overflow}, 1);
    check("R4 irq on refused address", {31'd0, irq}, 1);
    check("R4 buffer kept on address", {24'd0, rx_data}, 32'h20);
    bus_stop();
    pulse_rd(); pulse_clr_ovf(); pulse_clr_irq();

    // R8: Start/Stop interrupts
    ss_irq_en = 1'b1;
    bus_start();
    check("R8 irq on Start", {31'd0, irq}, 1);
    pulse_clr_irq();
    bus_stop();
    check("R8 irq on Stop", {31'd0, irq}, 1);
    pulse_clr_irq();
    ss_irq_en = 1'b0;
    bus_start();
    check("R8 no irq when option off", {31'd0, irq}, 0);
    bus_stop();
    check("R8 no irq on Stop when off", {31'd0, irq}, 0);

    // R7: 10-bit address 0x2A5 -> F4, A5
    ten_bit_mode = 1'b1;
    write_addr(8'hF4);
    bus_start();
    xfer(8'hF4, 1'b1, "R7 high byte ACK");
    check("R7 update flag after high byte", {31'd0, addr_update}, 1);
    check("R7 SCL held", {31'd0, scl_pull}, 1);
    pulse_rd(); pulse_clr_irq(); wait_q(Q);
    check("R7 read alone keeps SCL held", {31'd0, scl_pull}, 1);
    write_addr(8'hA5); wait_q(3);
    check("R7 write releases SCL", {30'd0, scl_pull, addr_update}, 0);
    xfer(8'hA5, 1'b1, "R7 low byte ACK");
    check("R7 update flag after low byte", {31'd0, addr_update}, 1);
    pulse_rd();
    write_addr(8'hF4); wait_q(3);
    check("R7 released for data", {31'd0, scl_pull}, 0);
    xfer(8'h77, 1'b1, "R7 data ACK");
    check("R7 data sets no update flag", {31'd0, addr_update}, 0);
    pulse_rd();
    bus_stop();

    // R7: wrong forms
    bus_start();
    xfer(8'hF5, 1'b0, "R7 high byte with read bit NACK");
    check("R7 no stretch after NACK", {31'd0, scl_pull}, 0);
    bus_stop();
    bus_start();
    xfer(8'hF4, 1'b1, "R7 high byte ACK again");
    pulse_rd();
    write_addr(8'hA5); wait_q(3);
    xfer(8'hA6, 1'b0, "R7 wrong low byte NACK");
    check("R7 no stretch on wrong low byte", {30'd0, scl_pull, addr_update}, 0);
    bus_stop();

    check("R3 all expected bytes seen", exp_q.size(), 0);
    finish_run();
  end

endmodule